// File: doc/BRIEF.md
# Multi-channel inter-processor mailbox

This block carries fixed-size messages in one direction, from a sending processor to a receiving processor. Each side reaches it through its own simple 32-bit register port, with address, write strobe, write data, read strobe and read data. Both ports decode the same address layout. That layout has three bit-vector registers and one message window for each channel. Bit n of every bit-vector refers to channel n.

To send, the sender fills a channel's eight-word window and then sets that channel's bit in the trigger register. This raises the channel's pending flag. The receiver opens channels through its enable register. Its single level interrupt is high while any channel that is both open and pending exists. On an interrupt, the receiver reads the words from the same window offsets and then clears the pending flag by writing a one to the status bit. The sender polls its own status view until the bit reads zero, and only then sends the next message on that channel. The sender can read the receiver's enable mask, so it can avoid sending on a closed channel.

Top module: `ipc_mailbox`

## Requirements
- R1: The message word w (0..7) of channel n (0..3) is at byte address 0x10 + 32*n + 4*w on both ports. Addresses whose two low bits are not zero are unmapped.
- R2: A sender write to address 0x00 with bit n set, while channel n is enabled and not pending, sets channel n's pending flag. No other event sets it.
- R3: A trigger on channel n is ignored while channel n is disabled or already pending. The flag keeps its value and the buffer is unchanged.
- R4: Address 0x08 reads the pending flags (bit n = channel n) on both ports.
- R5: A receiver write to 0x08 clears each pending flag whose bit is 1 and leaves the other flags unchanged. A sender write to 0x08 has no effect.
- R6: The enable mask at 0x04 is written only by the receiver and can be read from both ports. A sender write to 0x04 has no effect.
- R7: The rx_irq output is high exactly while at least one channel is both enabled and pending. It is updated in the cycle after the write that changes either set.
- R8: Sender writes to a window are ignored while that channel is pending. Receiver writes to any window are always ignored.
- R9: Address 0x00 reads as zero, and any unmapped address reads as zero. Read data is registered: it is captured at the clock edge where the read strobe is high and then held.
- R10: After reset, all pending flags, enable bits, message words and read-data outputs are zero, and rx_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| s_addr | input | 8 | Sender byte address |
| s_wr | input | 1 | Sender write strobe |
| s_wdata | input | 32 | Sender write data |
| s_rd | input | 1 | Sender read strobe |
| s_rdata | output | 32 | Sender read data, registered |
| r_addr | input | 8 | Receiver byte address |
| r_wr | input | 1 | Receiver write strobe |
| r_wdata | input | 32 | Receiver write data |
| r_rd | input | 1 | Receiver read strobe |
| r_rdata | output | 32 | Receiver read data, registered |
| rx_irq | output | 1 | Level interrupt to the receiver |

## Verification
The assertions check the pending-flag rules on every cycle. A flag rises only on a legal trigger and always rises on one. It falls only on a receiver clear and always falls on one. The enable mask never moves on a sender write alone. The interrupt never drops without a receiver write. The directed scenarios cover what the assertions cannot: that message words reach the right window and survive a sender overwrite while pending, that the interrupt is masked and unmasked by the enable mask, that unmapped and trigger reads return zero, and that several channels can be triggered and cleared in one write.

// File: rtl/ipc_mbox_pkg.sv
// Shared definitions for the mailbox: the register regions that an address
// can decode to, and the fixed byte offsets of the control registers.
package ipc_mbox_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_TRIG,
        RG_ENAB,
        RG_STAT,
        RG_DATA
    } region_e;

    localparam int OFS_TRIG = 0;
    localparam int OFS_ENAB = 4;
    localparam int OFS_STAT = 8;
    localparam int OFS_WIN  = 16;

endpackage

// File: rtl/ipc_mbox_decode.sv
// Address decoder for one register port.
// It maps a byte address to a region, a channel index and a word index.
// Assumes WORDS and NCH are powers of two and that word accesses are
// aligned (low two address bits zero).
module ipc_mbox_decode
    import ipc_mbox_pkg::*;
#(
    parameter int AW    = 8,
    parameter int NCH   = 4,
    parameter int WORDS = 8,
    parameter int CW    = 2,
    parameter int WW    = 3
) (
    input  logic [AW-1:0] addr,
    output region_e       region,
    output logic [CW-1:0] ch,
    output logic [WW-1:0] word
);
    localparam int MSG_BYTES = WORDS * 4;
    localparam int WIN_END   = OFS_WIN + NCH * MSG_BYTES;
    localparam int CSH       = $clog2(MSG_BYTES);

    logic [AW:0] off;

    // offset of the address inside the message area
    always_comb off = {1'b0, addr} - (AW+1)'(OFS_WIN);

    // channel and word fields of the window offset
    always_comb begin
        ch   = CW'(off >> CSH);
        word = WW'(off >> 2);
    end

    // region classification
    always_comb begin
        region = RG_NONE;
        if (addr[1:0] == 2'b00) begin
            if (int'(addr) == OFS_TRIG)      region = RG_TRIG;
            else if (int'(addr) == OFS_ENAB) region = RG_ENAB;
            else if (int'(addr) == OFS_STAT) region = RG_STAT;
            else if (int'(addr) >= OFS_WIN && int'(addr) < WIN_END)
                                             region = RG_DATA;
        end
    end
endmodule

// File: rtl/ipc_mbox_chan.sv
// One mailbox channel: the message buffer and its pending flag.
// It takes sender word writes only while not pending. The flag is set by an
// accepted trigger and cleared by the receiver. It gives one read word for
// each port.
module ipc_mbox_chan #(
    parameter int WORDS = 8,
    parameter int WW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_word,
    input  logic [31:0]   wr_data,
    input  logic          trig,
    input  logic          clr,
    input  logic          open,
    input  logic [WW-1:0] s_idx,
    input  logic [WW-1:0] r_idx,
    output logic          pend,
    output logic [31:0]   s_word,
    output logic [31:0]   r_word
);
    logic [31:0] mem [WORDS];
    logic        pend_q;

    // message storage, frozen while a message is pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_en && !pend_q) begin
            mem[wr_word] <= wr_data;
        end
    end

    // pending flag: set by an accepted trigger, cleared only by the receiver
    always_ff @(posedge clk) begin
        if (!rst_n)                        pend_q <= 1'b0;
        else if (pend_q && clr)            pend_q <= 1'b0;
        else if (!pend_q && trig && open)  pend_q <= 1'b1;
    end

    // per-port word selection
    always_comb begin
        pend   = pend_q;
        s_word = mem[s_idx];
        r_word = mem[r_idx];
    end
endmodule

// File: rtl/ipc_mbox_rdmux.sv
// Read-data selection for one port. Trigger and unmapped addresses give
// zero. The enable and pending vectors are zero-extended. Window reads come
// from the addressed channel.
module ipc_mbox_rdmux
    import ipc_mbox_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  region_e           region,
    input  logic [CW-1:0]     ch,
    input  logic [NCH-1:0]    en,
    input  logic [NCH-1:0]    pend,
    input  logic [NCH*32-1:0] words,
    output logic [31:0]       rdata
);
    // select the value that the next read returns
    always_comb begin
        case (region)
            RG_ENAB: rdata = 32'(en);
            RG_STAT: rdata = 32'(pend);
            RG_DATA: rdata = words[ch*32 +: 32];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ipc_mailbox.sv
// One-direction multi-channel mailbox with a sender port and a receiver port.
// Assumes one clock for both ports and a synchronous active-low reset. Both
// ports decode the same layout. The receiver owns the enable mask and the
// clear of the pending flags. The sender owns the window writes and the
// triggers.
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int WORDS = 8,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] s_addr,
    input  logic          s_wr,
    input  logic [31:0]   s_wdata,
    input  logic          s_rd,
    output logic [31:0]   s_rdata,
    input  logic [AW-1:0] r_addr,
    input  logic          r_wr,
    input  logic [31:0]   r_wdata,
    input  logic          r_rd,
    output logic [31:0]   r_rdata,
    output logic          rx_irq
);
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1;

    region_e           s_reg, r_reg;
    logic [CW-1:0]     s_ch, r_ch;
    logic [WW-1:0]     s_wd, r_wd;
    logic [NCH-1:0]    en_q, pend_q;
    logic [NCH*32-1:0] s_words, r_words;
    logic [31:0]       s_nx, r_nx;
    logic              s_trig_wr, s_dat_wr, r_en_wr, r_clr_wr;

    ipc_mbox_decode #(.AW(AW), .NCH(NCH), .WORDS(WORDS), .CW(CW), .WW(WW)) u_sdec (
        .addr(s_addr), .region(s_reg), .ch(s_ch), .word(s_wd));
    ipc_mbox_decode #(.AW(AW), .NCH(NCH), .WORDS(WORDS), .CW(CW), .WW(WW)) u_rdec (
        .addr(r_addr), .region(r_reg), .ch(r_ch), .word(r_wd));

    // write strobes qualified by the owning port and region
    always_comb begin
        s_trig_wr = s_wr && (s_reg == RG_TRIG);
        s_dat_wr  = s_wr && (s_reg == RG_DATA);
        r_en_wr   = r_wr && (r_reg == RG_ENAB);
        r_clr_wr  = r_wr && (r_reg == RG_STAT);
    end

    // receiver-owned enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (r_en_wr) en_q <= r_wdata[NCH-1:0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ipc_mbox_chan #(.WORDS(WORDS), .WW(WW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (s_dat_wr && (s_ch == CW'(g))),
            .wr_word (s_wd),
            .wr_data (s_wdata),
            .trig    (s_trig_wr && s_wdata[g]),
            .clr     (r_clr_wr && r_wdata[g]),
            .open    (en_q[g]),
            .s_idx   (s_wd),
            .r_idx   (r_wd),
            .pend    (pend_q[g]),
            .s_word  (s_words[g*32 +: 32]),
            .r_word  (r_words[g*32 +: 32])
        );
    end

    ipc_mbox_rdmux #(.NCH(NCH), .CW(CW)) u_smux (
        .region(s_reg), .ch(s_ch), .en(en_q), .pend(pend_q), .words(s_words), .rdata(s_nx));
    ipc_mbox_rdmux #(.NCH(NCH), .CW(CW)) u_rmux (
        .region(r_reg), .ch(r_ch), .en(en_q), .pend(pend_q), .words(r_words), .rdata(r_nx));

    // registered read data for each port, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (s_rd) s_rdata <= s_nx;
            if (r_rd) r_rdata <= r_nx;
        end
    end

    // level interrupt for enabled, pending channels
    always_comb rx_irq = |(en_q & pend_q);
endmodule

// File: rtl/ipc_mailbox_chk.sv
// Checker for the mailbox: pending-flag set and clear rules, enable
// ownership, interrupt fall cause and read data after reset.
// It is attached to every ipc_mailbox instance by the bind below.
module ipc_mailbox_chk #(
    parameter int NCH = 4,
    parameter int AW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  s_addr,
    input logic           s_wr,
    input logic [31:0]    s_wdata,
    input logic [AW-1:0]  r_addr,
    input logic           r_wr,
    input logic [31:0]    r_wdata,
    input logic [31:0]    s_rdata,
    input logic           rx_irq,
    input logic [NCH-1:0] en_q,
    input logic [NCH-1:0] pend_q
);
    for (genvar g = 0; g < NCH; g++) begin : g_a
        // R2: a legal trigger raises the flag
        a_r2_trig_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (s_wr && s_addr == AW'(0) && s_wdata[g] && en_q[g] && !pend_q[g]) |=> pend_q[g]);
        // R2: nothing else raises the flag
        a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_q[g] && !(s_wr && s_addr == AW'(0) && s_wdata[g])) |=> !pend_q[g]);
        // R3: a pending flag holds until the receiver clears it
        a_r3_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[g] && !(r_wr && r_addr == AW'(8) && r_wdata[g])) |=> pend_q[g]);
        // R5: a receiver clear drops the flag
        a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[g] && r_wr && r_addr == AW'(8) && r_wdata[g]) |=> !pend_q[g]);
    end

    // R6: the sender cannot move the enable mask
    a_r6_enable_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_wr) |=> $stable(en_q));

    // R7: the interrupt drops only after a receiver write
    a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_irq) |-> $past(r_wr));

    // R10: read data is zero straight after reset
    a_r10_reset_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (s_rdata == 32'd0));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_wr(s_wr), .s_wdata(s_wdata),
    .r_addr(r_addr), .r_wr(r_wr), .r_wdata(r_wdata), .s_rdata(s_rdata),
    .rx_irq(rx_irq), .en_q(en_q), .pend_q(pend_q));

// File: tb/ipc_mailbox_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  s_addr = '0, r_addr = '0;
    logic        s_wr = 1'b0, s_rd = 1'b0, r_wr = 1'b0, r_rd = 1'b0;
    logic [31:0] s_wdata = '0, r_wdata = '0;
    logic [31:0] s_rdata, r_rdata;
    logic        rx_irq;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ipc_mailbox u_ipc_mailbox (
        .clk(clk), .rst_n(rst_n),
        .s_addr(s_addr), .s_wr(s_wr), .s_wdata(s_wdata), .s_rd(s_rd), .s_rdata(s_rdata),
        .r_addr(r_addr), .r_wr(r_wr), .r_wdata(r_wdata), .r_rd(r_rd), .r_rdata(r_rdata),
        .rx_irq(rx_irq));

    function automatic logic [7:0] win(int ch, int w);
        return 8'(16 + 32*ch + 4*w);
    endfunction

    function automatic logic [31:0] pat(int ch, int w, int seed);
        return 32'(seed * 32'h01010101) ^ 32'((ch << 8) | w);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic s_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk); s_addr = a; s_wdata = d; s_wr = 1'b1;
        @(negedge clk); s_wr = 1'b0;
    endtask

    task automatic r_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk); r_addr = a; r_wdata = d; r_wr = 1'b1;
        @(negedge clk); r_wr = 1'b0;
    endtask

    task automatic s_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); s_addr = a; s_rd = 1'b1;
        @(negedge clk); s_rd = 1'b0; d = s_rdata;
    endtask

    task automatic r_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); r_addr = a; r_rd = 1'b1;
        @(negedge clk); r_rd = 1'b0; d = r_rdata;
    endtask

    task automatic fill(int ch, int seed);
        for (int w = 0; w < 8; w++) s_write(win(ch, w), pat(ch, w, seed));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R10 s_rdata after reset", s_rdata, 0);
        check("R10 r_rdata after reset", r_rdata, 0);
        check("R10 irq low", 32'(rx_irq), 0);
        s_read(8'h08, d); check("R10 status zero", d, 0);
        r_read(8'h04, d); check("R10 enable zero", d, 0);
        r_read(win(3, 7), d); check("R10 buffer zero", d, 0);
    endtask

    task automatic t_closed_trigger;
        logic [31:0] d;
        fill(0, 1);
        s_write(8'h00, 32'h1);
        s_read(8'h08, d); check("R3 trigger on closed channel ignored", d, 0);
        check("R3 irq stays low", 32'(rx_irq), 0);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        r_write(8'h04, 32'hF);
        s_read(8'h04, d); check("R6 sender sees enable", d, 32'hF);
        s_write(8'h04, 32'h0);
        r_read(8'h04, d); check("R6 sender enable write ignored", d, 32'hF);
    endtask

    task automatic t_send_receive;
        logic [31:0] d;
        fill(2, 5);
        s_write(8'h00, 32'h4);
        check("R7 irq after trigger", 32'(rx_irq), 1);
        s_read(8'h08, d); check("R2 sender status pending", d, 32'h4);
        r_read(8'h08, d); check("R4 receiver status pending", d, 32'h4);
        for (int w = 0; w < 8; w++) begin
            r_read(win(2, w), d); check("R1 receiver window word", d, pat(2, w, 5));
        end
        s_read(win(0, 3), d); check("R1 sender window ch0", d, pat(0, 3, 1));
    endtask

    task automatic t_pending_protect;
        logic [31:0] d;
        s_write(win(2, 0), 32'hDEADBEEF);
        r_read(win(2, 0), d); check("R8 sender write while pending ignored", d, pat(2, 0, 5));
        r_write(win(2, 1), 32'h12345678);
        r_read(win(2, 1), d); check("R8 receiver window write ignored", d, pat(2, 1, 5));
        s_write(8'h00, 32'h4);
        s_write(8'h08, 32'h4);
        s_read(8'h08, d); check("R5 sender status write ignored", d, 32'h4);
        r_write(8'h08, 32'h0);
        s_read(8'h08, d); check("R5 zero write keeps flag", d, 32'h4);
        r_write(8'h08, 32'h4);
        s_read(8'h08, d); check("R5 clear drops flag", d, 0);
        check("R7 irq low after clear", 32'(rx_irq), 0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        s_write(8'h00, 32'h2);
        check("R7 irq on ch1", 32'(rx_irq), 1);
        r_write(8'h04, 32'hD);
        check("R7 masked pending gives no irq", 32'(rx_irq), 0);
        s_read(8'h08, d); check("R4 flag kept while masked", d, 32'h2);
        s_write(8'h00, 32'h2);
        r_write(8'h04, 32'hF);
        check("R7 irq after unmask", 32'(rx_irq), 1);
        r_write(8'h08, 32'h2);
        check("R7 irq low", 32'(rx_irq), 0);
        r_write(8'h04, 32'hD);
        s_write(8'h00, 32'h2);
        s_read(8'h08, d); check("R3 trigger on disabled ch1 ignored", d, 0);
        r_write(8'h04, 32'hF);
    endtask

    task automatic t_multi;
        logic [31:0] d;
        s_write(8'h00, 32'hB);
        s_read(8'h08, d); check("R2 multi trigger", d, 32'hB);
        r_write(8'h08, 32'h1);
        r_read(8'h08, d); check("R5 partial clear", d, 32'hA);
        check("R7 irq still high", 32'(rx_irq), 1);
        r_write(8'h08, 32'hF);
        r_read(8'h08, d); check("R5 clear all", d, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        s_read(8'h00, d); check("R9 trigger reads zero", d, 0);
        s_read(8'h0C, d); check("R9 unmapped 0x0C zero", d, 0);
        r_read(8'h90, d); check("R9 above window zero", d, 0);
        r_read(8'h11, d); check("R1 unaligned unmapped", d, 0);
        s_write(8'h0C, 32'hFFFF_FFFF);
        s_read(8'h08, d); check("R9 unmapped write no effect", d, 0);
        r_read(8'h04, d);
        r_addr = 8'h08;
        repeat (2) @(negedge clk);
        check("R9 read data held without strobe", r_rdata, 32'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_closed_trigger;
        t_enable;
        t_send_receive;
        t_pending_protect;
        t_mask;
        t_multi;
        t_unmapped;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule